// File: doc/BRIEF.md
# Hibernate Sequencer with Wake Debounce and Reset Stretch

This block runs in the slow always-on clock domain and sequences a chip into and out of a low-power hibernate state. Software enters hibernate by writing a one to a command register on a simple register bus. While hibernating, the block drops its power-enable output and watches an active-low wake pin.

A wake request is accepted only after the pin has been seen low for a programmed number of consecutive clock samples. A shorter pulse is treated as a glitch and restarts the count. On acceptance, power-enable rises again. The block then holds an active-low system reset output low for a programmed number of ticks, releases it, and goes back to the active state.

Both durations are programmed through bus registers. Only an upper field of each register is stored, and the five lowest bits always read as zero. With a 32 kHz clock, the debounce window reaches about 2 s and the reset stretch about 125 ms.

Top module: `hib_sequencer`

## Requirements
- R1: After reset, `pwrEn` is 1, `sysRstN` is 1, and the registers at 0x20, 0x24 and 0x28 read as zero.
- R2: The debounce register at offset 0x24 stores only bits 15:5 of a write. Every other bit reads as 0 (a write of 0xFFFFFFFF reads back 0x0000FFE0).
- R3: The reset-stretch register at offset 0x28 stores only bits 11:5 of a write. Every other bit reads as 0 (a write of 0xFFFFFFFF reads back 0x00000FE0, and a write of 0x1F reads back 0).
- R4: In the active state, a write to offset 0x20 with data bit 0 set makes `pwrEn` 0 from the next cycle.
  - A write there with bit 0 clear has no effect.
  - Offset 0x20 always reads 0.
- R5: While hibernating with debounce value F, the wake is accepted on the (F+1)-th consecutive sample of `wakeN` low. From the following cycle, `pwrEn` is 1 and `sysRstN` is 0.
- R6: A sample of `wakeN` high while hibernating restarts the debounce count from zero. The block stays in hibernate with `pwrEn` 0.
- R7: With reset-stretch value R, `sysRstN` stays low for exactly R+1 cycles after acceptance and then returns to 1, with `pwrEn` 1 (active state).
- R8: The following have no effect on the outputs:
  - a hibernate command written while the reset stretch is running;
  - `wakeN` going low while active.
- R9: With a debounce value of 0, the first low sample of `wakeN` in hibernate is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| wakeN | input | 1 | Active-low wake pin |
| pwrEn | output | 1 | Power enable, low while hibernating |
| sysRstN | output | 1 | Active-low system reset during the post-wake stretch |

## Verification
The assertions take `wakeN` and the bus as already synchronous to `clk`: no synchronizer is inside the block. They also assume a write lasts one cycle per strobe. The stimulus changes every input just after a rising edge and pulses `busWr` for single cycles. Debounce values stay well below the counter's range, so the increment never wraps. Glitch pulses shorter than the programmed window are chained to show that non-consecutive low samples never add up to an acceptance.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_HIBER   = 2'd1,
    ST_RSTHOLD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;
endpackage

// File: rtl/hib_datapath.sv
module hib_datapath
  import hib_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int HIB_OFS  = 'h20,
  parameter int FILT_OFS = 'h24,
  parameter int RST_OFS  = 'h28,
  parameter int FIELD_LO = 5,
  parameter int FILT_HI  = 15,
  parameter int RST_HI   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  cntCmd_t           cmd,
  output logic              hibReq,
  output logic              filtHit,
  output logic              rstHit
);
  localparam int CNT_W = FILT_HI + 1;

  function automatic logic [DATA_W-1:0] fieldMask(input int hi, input int lo);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] FILT_MASK = fieldMask(FILT_HI, FIELD_LO);
  localparam logic [DATA_W-1:0] RST_MASK  = fieldMask(RST_HI, FIELD_LO);

  logic [DATA_W-1:0] filtReg, rstReg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReg <= '0;
      rstReg  <= '0;
    end else if (busWr) begin
      if (busAddr == ADDR_W'(FILT_OFS)) filtReg <= busWdata & FILT_MASK;
      if (busAddr == ADDR_W'(RST_OFS))  rstReg  <= busWdata & RST_MASK;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(FILT_OFS)) busRdata = filtReg;
    else if (busAddr == ADDR_W'(RST_OFS)) busRdata = rstReg;
  end

  assign hibReq = busWr && (busAddr == ADDR_W'(HIB_OFS)) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.cntClr)  cnt <= '0;
    else if (cmd.cntInc)  cnt <= cnt + 1'b1;
  end

  assign filtHit = (DATA_W'(cnt) == filtReg);
  assign rstHit  = (DATA_W'(cnt) == rstReg);

  // R2
  filt_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtReg & ~FILT_MASK) == '0);
  // R3
  rst_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstReg & ~RST_MASK) == '0);
  // R6
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntClr |=> cnt == '0);
  // R5
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.cntInc && !cmd.cntClr) |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hibReq,
  input  logic    filtHit,
  input  logic    rstHit,
  input  logic    wakeN,
  output cntCmd_t cmd,
  output logic    pwrEn,
  output logic    sysRstN
);
  seqState_t state, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    cmd      = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (hibReq) begin
          nxtState   = ST_HIBER;
          cmd.cntClr = 1'b1;
        end
      end
      ST_HIBER: begin
        if (wakeN) begin
          cmd.cntClr = 1'b1;
        end else if (filtHit) begin
          nxtState   = ST_RSTHOLD;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_RSTHOLD: begin
        if (rstHit) begin
          nxtState   = ST_ACTIVE;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      default: nxtState = ST_ACTIVE;
    endcase
  end

  assign pwrEn   = (state != ST_HIBER);
  assign sysRstN = (state != ST_RSTHOLD);

  // R4
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> $past(hibReq));
  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> $past(rstHit));
  // R5
  pwr_rst_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |-> pwrEn);
  // R6
  hold_hiber_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIBER && wakeN) |=> state == ST_HIBER);
endmodule

// File: rtl/hib_sequencer.sv
module hib_sequencer
  import hib_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int HIB_OFS  = 'h20,
  parameter int FILT_OFS = 'h24,
  parameter int RST_OFS  = 'h28,
  parameter int FIELD_LO = 5,
  parameter int FILT_HI  = 15,
  parameter int RST_HI   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wakeN,
  output logic              pwrEn,
  output logic              sysRstN
);
  cntCmd_t cmd;
  logic    hibReq, filtHit, rstHit;

  hib_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIB_OFS(HIB_OFS), .FILT_OFS(FILT_OFS),
    .RST_OFS(RST_OFS), .FIELD_LO(FIELD_LO), .FILT_HI(FILT_HI), .RST_HI(RST_HI)
  ) uDp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmd(cmd),
    .hibReq(hibReq), .filtHit(filtHit), .rstHit(rstHit)
  );

  hib_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hibReq(hibReq), .filtHit(filtHit),
    .rstHit(rstHit), .wakeN(wakeN), .cmd(cmd), .pwrEn(pwrEn),
    .sysRstN(sysRstN)
  );
endmodule

// File: tb/tb_hib_sequencer.sv
module tb_hib_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wakeN = 1'b1;
  logic        pwrEn, sysRstN;

  hib_sequencer dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wakeN(wakeN),
    .pwrEn(pwrEn), .sysRstN(sysRstN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          cyc;
    bit          isRd;
    logic [31:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every expectation scheduled for the current cycle
  always @(negedge clk) begin
    int i;
    i = 0;
    while (i < expQ.size()) begin
      if (expQ[i].cyc == cyc) begin
        logic [31:0] act;
        act = expQ[i].isRd ? busRdata : {30'd0, pwrEn, sysRstN};
        nChecks++;
        if (act !== expQ[i].val) begin
          nFails++;
          $display("FAIL %s cycle %0d %s actual=%h expected=%h", expQ[i].tag,
                   cyc, expQ[i].isRd ? "rdata" : "{pwrEn,sysRstN}", act, expQ[i].val);
        end
        expQ.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic expectAt(input int c, input bit isRd, input logic [31:0] v,
                          input string tag);
    expItem_t it;
    it.cyc = c; it.isRd = isRd; it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick(1);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] v, input string tag);
    busAddr = a;
    expectAt(cyc, 1'b1, v, tag);
    tick(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      nChecks += expQ.size();
      foreach (expQ[k]) begin
        nFails++;
        $display("FAIL %s cycle %0d never compared actual=none expected=%h",
                 expQ[k].tag, expQ[k].cyc, expQ[k].val);
      end
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick(1);

    // R1 reset state
    expectAt(cyc, 1'b0, 32'd3, "R1");
    rdChk(8'h24, 32'h0, "R1");
    rdChk(8'h28, 32'h0, "R1");
    rdChk(8'h20, 32'h0, "R1");

    // R2 / R3 field masking
    busWrite(8'h24, 32'hFFFF_FFFF);
    rdChk(8'h24, 32'h0000_FFE0, "R2");
    busWrite(8'h28, 32'hFFFF_FFFF);
    rdChk(8'h28, 32'h0000_0FE0, "R3");
    busWrite(8'h24, 32'd32);
    busWrite(8'h28, 32'd32);
    rdChk(8'h24, 32'd32, "R2");

    // R8 wake pin low while active has no effect
    wakeN = 1'b0;
    expectAt(cyc + 1, 1'b0, 32'd3, "R8");
    expectAt(cyc + 3, 1'b0, 32'd3, "R8");
    tick(3);
    wakeN = 1'b1;
    tick(1);

    // R4 hibernate command with bit 0 clear is ignored, then set enters
    busWr = 1'b1; busAddr = 8'h20; busWdata = 32'h2;
    expectAt(cyc + 1, 1'b0, 32'd3, "R4");
    tick(1);
    busWdata = 32'h1;
    expectAt(cyc + 1, 1'b0, 32'd1, "R4");
    tick(1);
    busWr = 1'b0;
    rdChk(8'h20, 32'h0, "R4");

    // R6 glitches shorter than the window restart the count
    wakeN = 1'b0; tick(10);
    wakeN = 1'b1; tick(1);
    wakeN = 1'b0; tick(20);
    wakeN = 1'b1; tick(1);
    wakeN = 1'b0; tick(20);
    expectAt(cyc, 1'b0, 32'd1, "R6");
    wakeN = 1'b1;
    expectAt(cyc + 1, 1'b0, 32'd1, "R6");
    tick(2);

    // R5 acceptance after F+1 = 33 consecutive low samples, R7 stretch of R+1
    begin
      int c0, e0;
      c0 = cyc;
      e0 = c0 + 33;
      wakeN = 1'b0;
      expectAt(c0 + 32, 1'b0, 32'd1, "R5");
      expectAt(e0, 1'b0, 32'd2, "R5");
      expectAt(e0 + 32, 1'b0, 32'd2, "R7");
      expectAt(e0 + 33, 1'b0, 32'd3, "R7");
      expectAt(e0 + 35, 1'b0, 32'd3, "R8");
      tick(e0 + 5 - cyc);
      // R8 hibernate command during the reset stretch is ignored
      busWrite(8'h20, 32'h1);
      wakeN = 1'b1;
      tick(e0 + 37 - cyc);
    end

    // R9 zero debounce with zero reset stretch
    busWrite(8'h24, 32'h0);
    busWrite(8'h28, 32'h1F);
    rdChk(8'h28, 32'h0, "R3");
    busWrite(8'h20, 32'h1);
    expectAt(cyc, 1'b0, 32'd1, "R9");
    wakeN = 1'b0;
    expectAt(cyc + 1, 1'b0, 32'd2, "R9");
    expectAt(cyc + 2, 1'b0, 32'd3, "R7");
    tick(4);
    wakeN = 1'b1;
    tick(2);
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
      finishRun();
    end
  end
endmodule